// File: doc/BRIEF.md
# Two-Wire Master Interrupt Status and Mask Bank

This block holds the interrupt state of a two-wire bus master. The controller core raises single-cycle event pulses, one wire per event kind. Each pulse sets a sticky status bit. The status bit stays set until software clears it by writing a one to its position in the status register. Masking has no effect on the status bits.

The mask has no plain writable register. Software changes it through two write-only strobes: an arm register sets the mask bits that are one in the written word, and a disarm register clears them. The current mask can be read back at its own offset. A single registered interrupt line is high whenever any status bit is pending with its mask bit set.

Event positions are fixed, because the controller core and software both decode them:

| Bit | Event |
|-----|-------|
| 0 | transfer complete |
| 1 | data threshold |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 9 | arbitration lost |

Bit 8 is reserved.

Top module: `tw_irq_bank`

## Requirements
- R1: After reset, the status bits, the mask bits and `irq` are all zero.
- R2: An event pulse on bit i sets status bit i. The bit then stays set, whatever the mask holds, until software clears it.
- R3: A write to offset 0x10 clears exactly the status bits that are one in the written data. All other status bits are unchanged.
- R4: If an event pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R5: A write to offset 0x24 sets the mask bits that are one in the written data. All other mask bits are unchanged.
- R6: A write to offset 0x28 clears the mask bits that are one in the written data. All other mask bits are unchanged.
- R7: Reads are combinational on `bus_addr`. Offset 0x10 returns the status bits and offset 0x20 returns the mask bits. Offsets 0x24, 0x28 and any other offset return zero.
- R8: `irq` is registered. It is high in the cycle after the register state holds at least one bit that is set in both status and mask.
- R9: Bit 8 and every bit above 9 are not implemented. They read as zero in both status and mask, and events or writes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset for reads and writes |
| wr_en | input | 1 | Write strobe for the register at `bus_addr` |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data for `bus_addr` |
| evt_pulse | input | EVT_W (10) | Event pulses from the controller core, one bit per event |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can hit the same status bit in the same cycle: a new event pulse and a software clear of that bit. The bench provokes this by driving a status write of 0x004 together with an NACK pulse (bit 2). It then reads back status and expects the bit still set, with `irq` high through the enabled mask. Mask changes and status clears are also interleaved with `irq` samples. These samples are taken both in the cycle right after the write, where the old level is still expected, and one cycle later, where the new level is expected.

// File: rtl/tw_irq_pkg.sv
package tw_irq_pkg;
   // register byte offsets
   localparam logic [7:0] OFS_STATUS = 8'h10;
   localparam logic [7:0] OFS_MASK   = 8'h20;
   localparam logic [7:0] OFS_ARM    = 8'h24;
   localparam logic [7:0] OFS_DISARM = 8'h28;

   // event bit positions, decoded by the controller core and by software
   localparam int EV_DONE     = 0;
   localparam int EV_THRESH   = 1;
   localparam int EV_NACK     = 2;
   localparam int EV_TIMEOUT  = 3;
   localparam int EV_TGT_RDY  = 4;
   localparam int EV_RX_OVF   = 5;
   localparam int EV_TX_OVF   = 6;
   localparam int EV_RX_UNF   = 7;
   localparam int EV_ARB_LOST = 9;

   localparam int EV_COUNT = 10;
   localparam logic [EV_COUNT-1:0] EV_IMPL = 10'h2FF;
endpackage

// File: rtl/tw_irq_status.sv
module tw_irq_status #(
   parameter int EVT_W = 10,
   parameter logic [EVT_W-1:0] IMPL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [EVT_W-1:0] clr_bits,
   input  logic [EVT_W-1:0] evt,
   output logic [EVT_W-1:0] status
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               status[i] <= 1'b0;
            else if (evt[i])
               status[i] <= 1'b1;          // a new event beats a clear
            else if (clr_en && clr_bits[i])
               status[i] <= 1'b0;
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = evt[i] | clr_bits[i];
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/tw_irq_mask.sv
module tw_irq_mask #(
   parameter int EVT_W = 10,
   parameter logic [EVT_W-1:0] IMPL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_en,
   input  logic             disarm_en,
   input  logic [EVT_W-1:0] bits,
   output logic [EVT_W-1:0] mask
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask[i] <= 1'b0;
            else if (arm_en && bits[i])
               mask[i] <= 1'b1;
            else if (disarm_en && bits[i])
               mask[i] <= 1'b0;
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = bits[i];
         assign mask[i] = 1'b0;
      end
   end
endmodule

// File: rtl/tw_irq_line.sv
module tw_irq_line #(
   parameter int EVT_W = 10,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] status,
   input  logic [EVT_W-1:0] mask,
   output logic             irq
);
   logic pending;
   assign pending = |(status & mask);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pending;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk & rst_n;
      assign irq = pending;
   end
endmodule

// File: rtl/tw_irq_bank.sv
module tw_irq_bank #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int EVT_W  = tw_irq_pkg::EV_COUNT,
   parameter logic [EVT_W-1:0] IMPL = tw_irq_pkg::EV_IMPL,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [EVT_W-1:0]  evt_pulse,
   output logic              irq
);
   import tw_irq_pkg::*;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);
   localparam logic [ADDR_W-1:0] A_DISARM = ADDR_W'(OFS_DISARM);

   if (EVT_W > DATA_W) begin : g_bad_width
      $error("tw_irq_bank: EVT_W must not exceed DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("tw_irq_bank: ADDR_W too small for the register offsets");
   end

   logic [EVT_W-1:0] wbits;
   logic             hit_status, hit_arm, hit_disarm;
   logic [EVT_W-1:0] status_q, mask_q;

   assign wbits      = wr_data[EVT_W-1:0];
   assign hit_status = wr_en && (bus_addr == A_STATUS);
   assign hit_arm    = wr_en && (bus_addr == A_ARM);
   assign hit_disarm = wr_en && (bus_addr == A_DISARM);

   if (DATA_W > EVT_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:EVT_W];
   end

   tw_irq_status #(.EVT_W(EVT_W), .IMPL(IMPL)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (hit_status),
      .clr_bits (wbits),
      .evt      (evt_pulse),
      .status   (status_q)
   );

   tw_irq_mask #(.EVT_W(EVT_W), .IMPL(IMPL)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_en    (hit_arm),
      .disarm_en (hit_disarm),
      .bits      (wbits),
      .mask      (mask_q)
   );

   tw_irq_line #(.EVT_W(EVT_W), .REG_OUT(REG_OUT)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .mask   (mask_q),
      .irq    (irq)
   );

   always_comb begin
      rd_data = '0;
      if (bus_addr == A_STATUS)    rd_data = DATA_W'(status_q);
      else if (bus_addr == A_MASK) rd_data = DATA_W'(mask_q);
   end
endmodule

// File: rtl/tw_irq_bank_chk.sv
module tw_irq_bank_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int EVT_W  = 10,
   parameter logic [EVT_W-1:0] IMPL = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [EVT_W-1:0]  evt_pulse,
   input logic [EVT_W-1:0]  status_q,
   input logic [EVT_W-1:0]  mask_q,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(8'h10);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(8'h20);
   localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(8'h24);
   localparam logic [ADDR_W-1:0] A_DISARM = ADDR_W'(8'h28);

   logic [EVT_W-1:0] wb;
   assign wb = wr_data[EVT_W-1:0];

   // R2: every implemented event pulse leaves its status bit set
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse & IMPL)) |=> ((status_q & $past(evt_pulse & IMPL)) == $past(evt_pulse & IMPL)));

   // R2: without a status write, no set bit falls
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && bus_addr == A_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R3, R4: a clear removes the written bits except those hit by an event
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == A_STATUS) |=> ((status_q & $past(wb & ~evt_pulse)) == '0));

   // R5: arm sets the written mask bits
   a_r5_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == A_ARM) |=> ((mask_q & $past(wb & IMPL)) == $past(wb & IMPL)));

   // R6: disarm clears the written mask bits
   a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == A_DISARM) |=> ((mask_q & $past(wb)) == '0));

   // R8: irq follows pending state one cycle later
   a_r8_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(status_q & mask_q))));

   // R7, R9: strobe offsets read zero; unimplemented bits never read as one
   a_r7_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_ARM || bus_addr == A_DISARM) |-> (rd_data == '0));
   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STATUS || bus_addr == A_MASK) |-> ((rd_data & ~DATA_W'(IMPL)) == '0));
endmodule

bind tw_irq_bank tw_irq_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .IMPL(IMPL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .evt_pulse (evt_pulse),
   .status_q  (status_q),
   .mask_q    (mask_q),
   .irq       (irq)
);

// File: tb/tw_irq_bank_bench.sv
`timescale 1ns/1ps
module tw_irq_bank_bench;
   localparam logic [7:0] S  = 8'h10;
   localparam logic [7:0] M  = 8'h20;
   localparam logic [7:0] EN = 8'h24;
   localparam logic [7:0] DS = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [9:0]  evt_pulse = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit mon_req = 0;

   typedef struct {
      logic [31:0] exp;
      bit          is_irq;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   tw_irq_bank u_tw_irq_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse), .irq(irq)
   );

   // monitor: pops one expected item per requested sample
   always @(negedge clk) begin
      if (mon_req && sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         act = it.is_irq ? {31'd0, irq} : rd_data;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [9:0] e);
      bus_addr = a; wr_data = d; wr_en = 1'b1; evt_pulse = e;
      @(posedge clk); #1;
      wr_en = 1'b0; evt_pulse = '0; wr_data = '0;
   endtask

   task automatic pulse(input logic [9:0] e);
      evt_pulse = e;
      @(posedge clk); #1;
      evt_pulse = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      item_t it;
      it.exp = exp; it.is_irq = 1'b0; it.tag = tag;
      bus_addr = a;
      sb.push_back(it);
      mon_req = 1'b1;
      @(posedge clk); #1;
      mon_req = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      item_t it;
      it.exp = {31'd0, exp}; it.is_irq = 1'b1; it.tag = tag;
      sb.push_back(it);
      mon_req = 1'b1;
      @(posedge clk); #1;
      mon_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      rd(S, 32'h0, "R1 status after reset");
      rd(M, 32'h0, "R1 mask after reset");
      chk_irq(1'b0, "R1 irq after reset");

      pulse(10'h001);
      rd(S, 32'h001, "R2 done event sets bit0");
      chk_irq(1'b0, "R2 masked event no irq");
      pulse(10'h300);
      rd(S, 32'h201, "R9 bit8 event ignored, arb lost bit9 set");

      wr(EN, 32'h204, '0);
      chk_irq(1'b0, "R8 irq not yet in first cycle");
      chk_irq(1'b1, "R8 irq after one cycle");
      rd(M, 32'h204, "R7 mask readback");
      wr(EN, 32'h101, '0);
      rd(M, 32'h205, "R5 arm keeps others, R9 bit8 ignored");

      rd(EN, 32'h0, "R7 arm offset reads zero");
      rd(DS, 32'h0, "R7 disarm offset reads zero");
      rd(8'h00, 32'h0, "R7 unused offset reads zero");

      wr(S, 32'h001, '0);
      rd(S, 32'h200, "R3 clear only bit0");
      chk_irq(1'b1, "R8 arb lost still pending");

      wr(DS, 32'h200, '0);
      chk_irq(1'b1, "R8 old level right after disarm");
      chk_irq(1'b0, "R6 irq drops after disarm");
      rd(M, 32'h005, "R6 disarm clears only bit9");
      rd(S, 32'h200, "R2 status kept while unmasked");

      wr(S, 32'h004, 10'h004);
      rd(S, 32'h204, "R4 event wins over same-cycle clear");
      chk_irq(1'b1, "R4 nack pending and enabled");

      wr(S, 32'h204, '0);
      rd(S, 32'h0, "R3 clear two bits");
      chk_irq(1'b0, "R3 irq idle after clear");

      pulse(10'h3FF);
      rd(S, 32'h2FF, "R9 all events, bit8 stays zero");
      wr(EN, 32'hFFFF_FFFF, '0);
      rd(M, 32'h2FF, "R9 arm all, upper bits zero");
      chk_irq(1'b1, "R8 all enabled");
      wr(DS, 32'hFFFF_FFFF, '0);
      rd(M, 32'h0, "R6 disarm all");
      chk_irq(1'b0, "R6 irq low with empty mask");

      wr(EN, 32'h001, '0);
      rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      rd(S, 32'h0, "R1 status after second reset");
      rd(M, 32'h0, "R1 mask after second reset");
      chk_irq(1'b0, "R1 irq after second reset");

      @(posedge clk); #1;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard actual %0d left expected 0", sb.size());
      end
      finish_run();
   end
endmodule